// File: doc/BRIEF.md
# Data Enable Timing Monitor

This block watches the data-enable strobe that accompanies pixel data on the transmit side of a serial video link. It measures, in pixel clocks, how long the strobe stays high, how long it stays low and how far apart its rising edges are. It then checks those lengths against the rules of the selected link mode. In the sync-locked mode every high and low phase must last at least two clocks. When the high-frequency option is also on, each phase must last at least four clocks, and the high time and the rising-edge period must both be even. In the sync-free mode no rule applies.

The first rule broken after reset or after a clear is held in a sticky flag, together with a cause code. The flag stays set until reset or until the clear input is pulsed. The block also models the receive-side data path: pixel data passes through while the strobe is high and is forced to zero while it is low, one register stage later.

Top module: `de_timing_monitor`

## Requirements
- R1: When `sync_free_i` is 1, no strobe length ever sets `viol_o`.
- R2: With `sync_free_i`=0 and `hf_mode_i`=0, a high phase shorter than 2 clocks sets cause 1 and a low phase shorter than 2 clocks sets cause 2. Phases of 2 or more clocks are compliant.
- R3: With `sync_free_i`=0 and `hf_mode_i`=1, the minimum length of both the high phase and the low phase is 4 clocks, reported with the same codes 1 and 2.
- R4: With `hf_mode_i`=1, a high phase of at least 4 clocks but an odd length sets cause 3.
- R5: With `hf_mode_i`=1, an odd number of clocks between consecutive rising edges of `de_i` sets cause 4.
- R6: The first rising edge after reset only starts the period measurement. The low phase before it and the period ending at it are never checked.
- R7: `viol_o` is sticky and `cause_o` keeps the first violation. If a short low phase and an odd period end in the same cycle, code 2 wins over code 4.
- R8: A 1 on `clr_i` clears `viol_o` and `cause_o` to 0 on the next clock. A violation detected in the same cycle as the clear is dropped.
- R9: Length counters saturate at 2^CNT_W−1. A saturated length counts as compliant for every rule.
- R10: `pix_o` equals the `pix_i` value of the previous clock when `de_i` was 1 in that clock, and 0 when it was 0.
- R11: A synchronous active-low reset leaves `viol_o`=0, `cause_o`=0 and `pix_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| de_i | input | 1 | Data-enable strobe |
| sync_free_i | input | 1 | Link mode: 1 = sync-free (no rules), 0 = sync-locked |
| hf_mode_i | input | 1 | High-frequency option for the sync-locked mode |
| clr_i | input | 1 | Clears the sticky violation |
| pix_i | input | DATA_W | Pixel data in |
| viol_o | output | 1 | Sticky violation flag |
| cause_o | output | 3 | Cause code: 0 none, 1 short high, 2 short low, 3 odd high, 4 odd period |
| pix_o | output | DATA_W | Gated pixel data, one clock after the input |

## Verification
The bench builds the monitor with CNT_W=6 and DATA_W=8. The narrow counter saturates at 63, so the saturation rule can be reached with strobe phases of about seventy clocks and tested with odd lengths that would otherwise be flagged. The eight-bit data width keeps the gating patterns short, while they still show that every bit passes through or is forced to zero.

// File: rtl/de_mon_pkg.sv
// Shared types for the data-enable timing monitor.
// Assumes: cause codes are fixed by the requirements (0..4).
package de_mon_pkg;

    // Violation cause codes, lower value wins on a tie
    typedef enum logic [2:0] {
        CAUSE_NONE       = 3'd0,
        CAUSE_SHORT_HIGH = 3'd1,
        CAUSE_SHORT_LOW  = 3'd2,
        CAUSE_ODD_HIGH   = 3'd3,
        CAUSE_ODD_PERIOD = 3'd4
    } cause_e;

    // Strobe edge events for the current clock
    typedef struct packed {
        logic rise;   // de_i is 1 now and was 0 in the previous clock
        logic fall;   // de_i is 0 now and was 1 in the previous clock
        logic armed;  // a rising edge has been seen since reset
    } de_edge_t;

    // Indices of the three length counters
    localparam int RUN_HIGH   = 0;
    localparam int RUN_LOW    = 1;
    localparam int RUN_PERIOD = 2;
    localparam int RUN_COUNT  = 3;

endpackage

// File: rtl/de_edge_tracker.sv
// Finds rising and falling edges of the data-enable strobe and records
// whether a first rising edge has occurred since reset.
// Assumes: de_i is synchronous to clk.
module de_edge_tracker
    import de_mon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     de_i,
    output de_edge_t edges_o
);

    logic de_q;
    logic armed_q;

    // Previous strobe value and the first-edge flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_q    <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            de_q <= de_i;
            if (de_i && !de_q) begin
                armed_q <= 1'b1;
            end
        end
    end

    // Combine the current strobe with the stored one into edge events
    always_comb begin
        edges_o.rise  = de_i && !de_q;
        edges_o.fall  = !de_i && de_q;
        edges_o.armed = armed_q;
    end

    // R6: once armed, the flag stays set until reset
    armed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |=> armed_q);

endmodule

// File: rtl/de_run_counter.sv
// Saturating length counter. A restart loads 1 (the current clock is the
// first of a new run); otherwise it counts up while advance is high and
// stops at all-ones.
// Assumes: the caller samples cnt_o in the event cycle, before the update.
module de_run_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             advance_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] SAT_VAL = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE_VAL = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Restart, advance or hold the run length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= ONE_VAL;
        end else if (advance_i && (cnt_q != SAT_VAL)) begin
            cnt_q <= cnt_q + ONE_VAL;
        end
    end

    assign cnt_o = cnt_q;

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == SAT_VAL && advance_i && !restart_i) |=> (cnt_q == SAT_VAL));

    // R9
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == ONE_VAL));

endmodule

// File: rtl/de_rule_checker.sv
// Applies the strobe timing rules at each edge event and reports a hit and
// its cause. The high time is judged at a falling edge. The low time and the
// period are judged at a rising edge, and only once armed.
// Assumes: counters hold the completed run length in the event cycle.
module de_rule_checker
    import de_mon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  de_edge_t         edges_i,
    input  logic             sync_free_i,
    input  logic             hf_mode_i,
    input  logic [CNT_W-1:0] high_len_i,
    input  logic [CNT_W-1:0] low_len_i,
    input  logic [CNT_W-1:0] period_len_i,
    output logic             hit_o,
    output cause_e           cause_o
);

    localparam logic [CNT_W-1:0] SAT_VAL = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] MIN_STD = CNT_W'(2);
    localparam logic [CNT_W-1:0] MIN_HF  = CNT_W'(4);

    // A length below the minimum that has not saturated
    function automatic logic too_short(input logic [CNT_W-1:0] len,
                                       input logic [CNT_W-1:0] min_len);
        return (len != SAT_VAL) && (len < min_len);
    endfunction

    // An odd length that has not saturated
    function automatic logic is_odd(input logic [CNT_W-1:0] len);
        return (len != SAT_VAL) && len[0];
    endfunction

    logic [CNT_W-1:0] min_len;

    // Pick the minimum phase length for the mode
    always_comb begin
        min_len = hf_mode_i ? MIN_HF : MIN_STD;
    end

    // Evaluate the rules, lowest cause code first
    always_comb begin
        cause_o = CAUSE_NONE;
        if (!sync_free_i) begin
            if (edges_i.fall) begin
                if (too_short(high_len_i, min_len)) begin
                    cause_o = CAUSE_SHORT_HIGH;
                end else if (hf_mode_i && is_odd(high_len_i)) begin
                    cause_o = CAUSE_ODD_HIGH;
                end
            end else if (edges_i.rise && edges_i.armed) begin
                if (too_short(low_len_i, min_len)) begin
                    cause_o = CAUSE_SHORT_LOW;
                end else if (hf_mode_i && is_odd(period_len_i)) begin
                    cause_o = CAUSE_ODD_PERIOD;
                end
            end
        end
        hit_o = (cause_o != CAUSE_NONE);
    end

endmodule

// File: rtl/de_viol_latch.sv
// Sticky violation register. Keeps the first cause until a clear or reset;
// a clear wins over a violation detected in the same clock.
// Assumes: hit_i and cause_i are valid every clock.
module de_viol_latch
    import de_mon_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr_i,
    input  logic   hit_i,
    input  cause_e cause_i,
    output logic   viol_o,
    output cause_e cause_o
);

    logic   viol_q;
    cause_e cause_q;

    // Capture the first violation, release it on clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else if (clr_i) begin
            viol_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else if (hit_i && !viol_q) begin
            viol_q  <= 1'b1;
            cause_q <= cause_i;
        end
    end

    assign viol_o  = viol_q;
    assign cause_o = cause_q;

    // R7
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_q && !clr_i) |=> (viol_q && $stable(cause_q)));

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!viol_q && cause_q == CAUSE_NONE));

endmodule

// File: rtl/de_data_gate.sv
// Receive-side data path model: registers pixel data while the strobe is
// high and drives zeros while it is low.
// Assumes: one register stage of latency is acceptable.
module de_data_gate #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              de_i,
    input  logic [DATA_W-1:0] pix_i,
    output logic [DATA_W-1:0] pix_o
);

    logic [DATA_W-1:0] pix_q;

    // Pass or blank the pixel word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else begin
            pix_q <= de_i ? pix_i : '0;
        end
    end

    assign pix_o = pix_q;

    // R10
    blank_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !de_i |=> (pix_o == '0));

    // R10
    pass_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de_i |=> (pix_o == $past(pix_i)));

endmodule

// File: rtl/de_timing_monitor.sv
// Top of the data-enable timing monitor. It tracks strobe edges, measures
// the high, low and period lengths with saturating counters, checks the
// mode rules, latches the first violation and gates the pixel data.
// Assumes: all inputs are synchronous to clk; mode bits are steady
// across a strobe phase.
module de_timing_monitor
    import de_mon_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              de_i,
    input  logic              sync_free_i,
    input  logic              hf_mode_i,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] pix_i,
    output logic              viol_o,
    output logic [2:0]        cause_o,
    output logic [DATA_W-1:0] pix_o
);

    de_edge_t         edges;
    logic [RUN_COUNT-1:0] run_restart;
    logic [RUN_COUNT-1:0] run_advance;
    logic [CNT_W-1:0] run_len [RUN_COUNT];
    logic             rule_hit;
    cause_e           rule_cause;
    cause_e           held_cause;

    de_edge_tracker u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .de_i    (de_i),
        .edges_o (edges)
    );

    // Restart and advance conditions of each length counter
    always_comb begin
        run_restart[RUN_HIGH]   = edges.rise;
        run_advance[RUN_HIGH]   = de_i;
        run_restart[RUN_LOW]    = edges.fall;
        run_advance[RUN_LOW]    = !de_i;
        run_restart[RUN_PERIOD] = edges.rise;
        run_advance[RUN_PERIOD] = 1'b1;
    end

    for (genvar g = 0; g < RUN_COUNT; g++) begin : g_run
        de_run_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (run_restart[g]),
            .advance_i (run_advance[g]),
            .cnt_o     (run_len[g])
        );
    end

    de_rule_checker #(
        .CNT_W (CNT_W)
    ) u_rules (
        .edges_i      (edges),
        .sync_free_i  (sync_free_i),
        .hf_mode_i    (hf_mode_i),
        .high_len_i   (run_len[RUN_HIGH]),
        .low_len_i    (run_len[RUN_LOW]),
        .period_len_i (run_len[RUN_PERIOD]),
        .hit_o        (rule_hit),
        .cause_o      (rule_cause)
    );

    de_viol_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .hit_i   (rule_hit),
        .cause_i (rule_cause),
        .viol_o  (viol_o),
        .cause_o (held_cause)
    );

    assign cause_o = held_cause;

    de_data_gate #(
        .DATA_W (DATA_W)
    ) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .de_i  (de_i),
        .pix_i (pix_i),
        .pix_o (pix_o)
    );

    // R1
    free_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_free_i && !viol_o) |=> !viol_o);

    // R7
    cause_flag_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol_o) |-> (cause_o != 3'd0));

endmodule

// File: tb/de_timing_monitor_bench.sv
`timescale 1ns/1ps
module de_timing_monitor_bench;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          de = 1'b0;
    logic          sync_free = 1'b0;
    logic          hf = 1'b0;
    logic          clr = 1'b0;
    logic [DW-1:0] pix = '0;
    logic          viol;
    logic [2:0]    cause;
    logic [DW-1:0] pix_out;

    int n_total = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    de_timing_monitor #(.DATA_W(DW), .CNT_W(6)) u_de_timing_monitor (
        .clk         (clk),
        .rst_n       (rst_n),
        .de_i        (de),
        .sync_free_i (sync_free),
        .hf_mode_i   (hf),
        .clr_i       (clr),
        .pix_i       (pix),
        .viol_o      (viol),
        .cause_o     (cause),
        .pix_o       (pix_out)
    );

    task automatic do_reset(input logic free_v, input logic hf_v);
        @(negedge clk);
        rst_n = 1'b0; de = 1'b0; clr = 1'b0; pix = '0;
        sync_free = free_v; hf = hf_v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic hold(input logic d, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            de = d;
        end
    endtask

    task automatic pulse(input int h, input int l);
        hold(1'b1, h);
        hold(1'b0, l);
    endtask

    // Waits one clock so the last drive is captured, then compares
    task automatic check_viol(input logic ev, input logic [2:0] ec, input string tag);
        @(negedge clk);
        n_total++;
        if (viol !== ev || cause !== ec) begin
            n_fail++;
            $display("FAIL %s: viol=%0d cause=%0d expected viol=%0d cause=%0d",
                     tag, viol, cause, ev, ec);
        end
    endtask

    task automatic t_reset();
        do_reset(1'b0, 1'b0);
        n_total++;
        @(negedge clk);
        if (viol !== 1'b0 || cause !== 3'd0 || pix_out !== '0) begin
            n_fail++;
            $display("FAIL R11 reset: viol=%0d cause=%0d pix=%0h expected 0 0 0",
                     viol, cause, pix_out);
        end
    endtask

    task automatic t_locked_std();
        do_reset(1'b0, 1'b0);
        pulse(2, 2); pulse(2, 2); pulse(3, 2); hold(1'b1, 1);
        check_viol(1'b0, 3'd0, "R2 min lengths ok");
        do_reset(1'b0, 1'b0);
        pulse(1, 3);
        check_viol(1'b1, 3'd1, "R2 short high");
        do_reset(1'b0, 1'b0);
        pulse(3, 1); hold(1'b1, 3);
        check_viol(1'b1, 3'd2, "R2 short low");
    endtask

    task automatic t_hf_min();
        do_reset(1'b0, 1'b1);
        pulse(4, 4); pulse(6, 4); hold(1'b1, 1);
        check_viol(1'b0, 3'd0, "R3 hf compliant");
        do_reset(1'b0, 1'b1);
        pulse(2, 6);
        check_viol(1'b1, 3'd1, "R3 hf short high");
        do_reset(1'b0, 1'b1);
        pulse(4, 2); hold(1'b1, 4);
        check_viol(1'b1, 3'd2, "R3 hf short low");
    endtask

    task automatic t_hf_parity();
        do_reset(1'b0, 1'b1);
        pulse(5, 5);
        check_viol(1'b1, 3'd3, "R4 odd high");
        do_reset(1'b0, 1'b1);
        pulse(4, 5); hold(1'b1, 1);
        check_viol(1'b1, 3'd4, "R5 odd period");
    endtask

    task automatic t_first_rise();
        do_reset(1'b0, 1'b1);
        hold(1'b0, 1); pulse(4, 4); hold(1'b1, 1);
        check_viol(1'b0, 3'd0, "R6 first rise unchecked");
    endtask

    task automatic t_sticky_clear();
        do_reset(1'b0, 1'b0);
        pulse(1, 1); hold(1'b1, 3);
        check_viol(1'b1, 3'd1, "R7 first cause kept");
        do_reset(1'b0, 1'b1);
        pulse(4, 3); hold(1'b1, 1);
        check_viol(1'b1, 3'd2, "R7 short low beats odd period");
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check_viol(1'b0, 3'd0, "R8 clear");
        // R8: short high ends in the same clock as the clear
        do_reset(1'b0, 1'b0);
        hold(1'b1, 1);
        @(negedge clk); de = 1'b0; clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check_viol(1'b0, 3'd0, "R8 clear beats violation");
    endtask

    task automatic t_free();
        do_reset(1'b1, 1'b0);
        pulse(1, 1); pulse(1, 1); pulse(3, 1); hold(1'b1, 1);
        check_viol(1'b0, 3'd0, "R1 sync-free std");
        do_reset(1'b1, 1'b1);
        pulse(5, 2); pulse(1, 5); hold(1'b1, 1);
        check_viol(1'b0, 3'd0, "R1 sync-free hf");
    endtask

    task automatic t_saturate();
        do_reset(1'b0, 1'b1);
        pulse(4, 4); pulse(67, 4); hold(1'b1, 1);
        check_viol(1'b0, 3'd0, "R9 saturated high and period");
        do_reset(1'b0, 1'b1);
        pulse(4, 4); pulse(4, 67); hold(1'b1, 4);
        check_viol(1'b0, 3'd0, "R9 saturated low and period");
    endtask

    task automatic t_gate();
        logic [DW-1:0] expv = '0;
        logic [DW-1:0] vals [6] = '{8'hA5, 8'h3C, 8'hFF, 8'h81, 8'h7E, 8'h00};
        logic          des  [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (i > 0) begin
                n_total++;
                if (pix_out !== expv) begin
                    n_fail++;
                    $display("FAIL R10 gate step %0d: pix=%0h expected %0h", i, pix_out, expv);
                end
            end
            if (i < 6) begin
                de = des[i]; pix = vals[i];
                expv = des[i] ? vals[i] : '0;
            end
        end
    endtask

    initial begin
        t_reset();
        t_locked_std();
        t_hf_min();
        t_hf_parity();
        t_first_rise();
        t_sticky_clear();
        t_free();
        t_saturate();
        t_gate();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule